// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

This block collects a set of interrupt request lines into a sticky request register, gates each request with a programmable mask bit, and resolves the surviving requests with a fixed-priority encoder. The encoder's code becomes the low bits of an 8-bit vector address, and its "any request" output drives a status flop. A program-controlled enable flop decides whether the processor may be interrupted.

At every instruction boundary (a one-clock pulse from the processor) the controller either lets the program counter advance by one, or, when both the enable and status flops are set, runs a four-step interrupt cycle. The cycle lowers the stack pointer, writes the old program counter to the stack slot, raises a one-cycle acknowledge, loads the vector into the program counter and clears the enable flop. The stack write leaves the block as a valid/ready stream. While valid is high and ready is low, the address and data are held and the cycle does not advance. The write is accepted on a clock edge where both are high. A small register write port lets software load the mask, set or clear the enable flop, and clear serviced request bits.

Top module: `pri_intr_ctrl`

## Requirements
- R1: A request bit is set on every clock edge where its input line is high. It stays set until software clears it. A clear and a new arrival on the same bit in the same cycle leave the bit set.
- R2: A write with `cfg_sel`=0 loads the mask from `cfg_data` (bit i = 1 lets source i through). The mask resets to all zeros. Masked requests reach neither the encoder nor the status flop.
- R3: Source 0 has the highest priority. `vad` carries the index of the lowest-numbered unmasked pending source in bits 1:0, and its upper bits are zero.
- R4: The status flop `ist` is 1 one cycle after any unmasked request is pending, and 0 one cycle after none is.
- R5: The enable flop `ien` resets to 0. It changes only on a write with `cfg_sel`=1, which loads `cfg_data[0]`, and through the interrupt cycle, which clears it. When both happen in the same cycle, the clear wins.
- R6: An instruction boundary starts an interrupt cycle only when `ien` and `ist` are both 1. Otherwise the boundary increments `pc` by one. Boundaries that arrive during an interrupt cycle are ignored.
- R7: The interrupt cycle runs these steps in order. First, `sp` decrements by one (its reset value is 0x80). Next, `pc` is written to the new `sp`. Then `ack` is held high for one cycle, with `vec_out` holding the vector captured at the boundary. Finally, `pc` takes that vector and `ien` clears.
- R8: A write with `cfg_sel`=2 clears every request bit whose `cfg_data` bit is 1. A write with `cfg_sel`=3 changes nothing.
- R9: The stack write holds `stk_valid`, `stk_addr` and `stk_data` steady while `stk_ready` is low, and the cycle waits until the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Interrupt request lines |
| boundary | input | 1 | End-of-instruction pulse |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 mask, 1 enable, 2 clear requests, 3 none |
| cfg_data | input | NUM_SRC | Write data |
| stk_ready | input | 1 | Stack write may complete |
| stk_valid | output | 1 | Stack write pending |
| stk_addr | output | AW | Stack slot address |
| stk_data | output | AW | Program counter being saved |
| ack | output | 1 | Interrupt acknowledge |
| vec_out | output | AW | Vector of the cycle in progress |
| vad | output | AW | Current encoder vector |
| pc | output | AW | Program counter |
| sp | output | AW | Stack pointer |
| ien | output | 1 | Interrupt enable flop |
| ist | output | 1 | Interrupt status flop |

## Verification
Two pairs of events can collide in one cycle. In the first, software clears a request bit while that same line is pulsing. The bench drives both on the same edge and expects the bit to survive, seen through `vad`. In the second, the program writes the enable bit in the acknowledge cycle that clears it. The bench issues the write exactly when `ack` is seen and expects `ien` to read 0 afterwards. A scoreboard queue also holds every expected stack write, so any extra or missing push is caught, including under back-pressure.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DEC  = 2'd1,
    SEQ_PUSH = 2'd2,
    SEQ_VEC  = 2'd3
  } seq_state_e;

  localparam logic [1:0] CFG_MASK = 2'd0;
  localparam logic [1:0] CFG_IEN  = 2'd1;
  localparam logic [1:0] CFG_CLR  = 2'd2;
endpackage

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] req
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        req[i] <= 1'b0;
      else if (irq_in[i])
        req[i] <= 1'b1;
      else if (clr_en && clr_bits[i])
        req[i] <= 1'b0;
    end

    assert_req_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_in[i] |=> req[i]);
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int NUM_SRC = 4,
  parameter int CW      = 2
) (
  input  logic [NUM_SRC-1:0] gated,
  output logic [CW-1:0]      code,
  output logic               valid
);
  always_comb begin
    code  = '0;
    valid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (gated[i]) begin
        code  = CW'(i);
        valid = 1'b1;
      end
    end
  end

  always_comb begin
    if (valid) begin
      assert_code_active_R3: assert (gated[code]);
      for (int j = 0; j < NUM_SRC; j++) begin
        if (j < int'(code))
          assert_no_higher_R3: assert (!gated[j]);
      end
    end
  end
endmodule

// File: rtl/pic_sequencer.sv
module pic_sequencer
  import pic_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          CW       = 2,
  parameter logic [AW-1:0] SP_RESET = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          ist,
  input  logic          ien_wr,
  input  logic          ien_val,
  input  logic [CW-1:0] code,
  input  logic          stk_ready,
  output logic          stk_valid,
  output logic [AW-1:0] stk_addr,
  output logic [AW-1:0] stk_data,
  output logic          ack,
  output logic [AW-1:0] vec_out,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] sp,
  output logic          ien
);
  seq_state_e    state;
  logic [CW-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      pc     <= '0;
      sp     <= SP_RESET;
      code_q <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (boundary) begin
            if (ien && ist) begin
              state  <= SEQ_DEC;
              code_q <= code;
            end else begin
              pc <= pc + AW'(1);
            end
          end
        end
        SEQ_DEC: begin
          sp    <= sp - AW'(1);
          state <= SEQ_PUSH;
        end
        SEQ_PUSH: begin
          if (stk_ready) state <= SEQ_VEC;
        end
        SEQ_VEC: begin
          pc    <= vec_out;
          state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ien <= 1'b0;
    else if (state == SEQ_VEC) ien <= 1'b0;
    else if (ien_wr)           ien <= ien_val;
  end

  assign stk_valid = (state == SEQ_PUSH);
  assign stk_addr  = sp;
  assign stk_data  = pc;
  assign ack       = (state == SEQ_VEC);
  assign vec_out   = AW'(code_q);

  assert_entry_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_IDLE && !(boundary && ien && ist)) |=> (state == SEQ_IDLE));
  assert_sp_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_DEC) |=> (sp == $past(sp) - AW'(1)));
  assert_ack_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (pc == $past(vec_out)));
  assert_ack_ien_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ien);
  assert_push_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) && $stable(stk_data)));
endmodule

// File: rtl/pri_intr_ctrl.sv
module pri_intr_ctrl
  import pic_pkg::*;
#(
  parameter int            NUM_SRC  = 4,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               boundary,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_sel,
  input  logic [NUM_SRC-1:0] cfg_data,
  input  logic               stk_ready,
  output logic               stk_valid,
  output logic [AW-1:0]      stk_addr,
  output logic [AW-1:0]      stk_data,
  output logic               ack,
  output logic [AW-1:0]      vec_out,
  output logic [AW-1:0]      vad,
  output logic [AW-1:0]      pc,
  output logic [AW-1:0]      sp,
  output logic               ien,
  output logic               ist
);
  localparam int CW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] gated;
  logic [CW-1:0]      code;
  logic               any_req;

  wire wr_mask = cfg_wr && (cfg_sel == CFG_MASK);
  wire wr_ien  = cfg_wr && (cfg_sel == CFG_IEN);
  wire wr_clr  = cfg_wr && (cfg_sel == CFG_CLR);

  pic_req_reg #(.NUM_SRC(NUM_SRC)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .clr_en   (wr_clr),
    .clr_bits (cfg_data),
    .req      (req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (wr_mask) mask <= cfg_data;
  end

  assign gated = req & mask;

  pic_prio_enc #(.NUM_SRC(NUM_SRC), .CW(CW)) u_enc (
    .gated (gated),
    .code  (code),
    .valid (any_req)
  );

  assign vad = AW'(code);

  always_ff @(posedge clk) begin
    if (!rst_n) ist <= 1'b0;
    else        ist <= any_req;
  end

  pic_sequencer #(.AW(AW), .CW(CW), .SP_RESET(SP_RESET)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .ist       (ist),
    .ien_wr    (wr_ien),
    .ien_val   (cfg_data[0]),
    .code      (code),
    .stk_ready (stk_ready),
    .stk_valid (stk_valid),
    .stk_addr  (stk_addr),
    .stk_data  (stk_data),
    .ack       (ack),
    .vec_out   (vec_out),
    .pc        (pc),
    .sp        (sp),
    .ien       (ien)
  );

  assert_ist_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|gated) |=> ist);
  assert_ist_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|gated) |=> !ist);
  assert_masked_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (vad == '0));
endmodule

// File: tb/sim_pri_intr_ctrl.sv
module sim_pri_intr_ctrl;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          boundary = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [N-1:0]  cfg_data = '0;
  logic          stk_ready = 1'b1;
  logic          stk_valid, ack, ien, ist;
  logic [AW-1:0] stk_addr, stk_data, vec_out, vad, pc, sp;

  always #5 clk = ~clk;

  pri_intr_ctrl #(.NUM_SRC(N), .AW(AW), .SP_RESET(8'h80)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .boundary(boundary),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .stk_ready(stk_ready), .stk_valid(stk_valid), .stk_addr(stk_addr),
    .stk_data(stk_data), .ack(ack), .vec_out(vec_out), .vad(vad),
    .pc(pc), .sp(sp), .ien(ien), .ist(ist)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [AW-1:0] data;
    logic [AW-1:0] vec;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  logic [AW-1:0] model_pc = '0;
  logic [AW-1:0] model_sp = 8'h80;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [N-1:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  // Monitor: compares stack writes and acknowledges against the queue
  always @(negedge clk) begin
    if (rst_n && stk_valid && stk_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected stack write", int'(stk_addr), 0);
      end else begin
        check(stk_addr == exp_q[0].addr, "R7 push address", int'(stk_addr), int'(exp_q[0].addr));
        check(stk_data == exp_q[0].data, "R7 push data", int'(stk_data), int'(exp_q[0].data));
      end
    end
    if (rst_n && ack) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected ack", 1, 0);
      end else begin
        check(vec_out == exp_q[0].vec, "R7 ack vector", int'(vec_out), int'(exp_q[0].vec));
        void'(exp_q.pop_front());
      end
    end
  end

  // Driver: boundary that must start an interrupt cycle
  task automatic run_intr(input logic [AW-1:0] exp_vec, input bit poke_ien);
    exp_t e;
    int   w;
    e.addr = model_sp - 8'd1;
    e.data = model_pc;
    e.vec  = exp_vec;
    exp_q.push_back(e);
    boundary = 1'b1;
    tick();
    boundary = 1'b0;
    w = 0;
    while (!ack && w < 50) begin tick(); w++; end
    if (poke_ien) begin
      cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_data = 4'b0001;
    end
    tick();
    cfg_wr = 1'b0;
    model_sp = model_sp - 8'd1;
    model_pc = exp_vec;
    check(pc == exp_vec, "R7 pc loaded with vector", int'(pc), int'(exp_vec));
    check(sp == model_sp, "R7 sp decremented", int'(sp), int'(model_sp));
    check(ien == 1'b0, "R5 ien cleared by cycle", int'(ien), 0);
  endtask

  task automatic plain_boundary();
    boundary = 1'b1;
    tick();
    boundary = 1'b0;
    model_pc = model_pc + 8'd1;
    tick();
    check(pc == model_pc, "R6 boundary advances pc", int'(pc), int'(model_pc));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    tick(3);
    rst_n = 1'b1;
    tick();
    check(pc == 8'h00 && sp == 8'h80, "R7 reset pc/sp", int'({pc, sp}), 16'h0080);
    check(ien == 1'b0, "R5 reset ien", int'(ien), 0);
    check(ist == 1'b0 && stk_valid == 1'b0 && ack == 1'b0, "R4 reset status", int'(ist), 0);

    // R2: reset mask blocks everything
    cfg_write(2'd1, 4'b0001);
    check(ien == 1'b1, "R5 ien set by write", int'(ien), 1);
    irq_in = 4'b1111; tick(); irq_in = '0;
    tick(2);
    check(ist == 1'b0, "R2 masked requests keep ist low", int'(ist), 0);
    plain_boundary();

    // R8: select 3 changes nothing
    cfg_write(2'd3, 4'b1111);
    tick(2);
    check(ist == 1'b0 && vad == 8'h00, "R8 select 3 ignored", int'(ist), 0);

    // R3/R4: partial mask
    cfg_write(2'd0, 4'b1100);
    check(vad == 8'h02, "R3 vector of source 2", int'(vad), 2);
    tick();
    check(ist == 1'b1, "R4 ist follows request", int'(ist), 1);
    cfg_write(2'd0, 4'b1111);
    check(vad == 8'h00, "R3 source 0 highest", int'(vad), 0);

    // R7: full interrupt cycle
    run_intr(8'h00, 1'b0);

    // R6: boundary with ien low just advances
    plain_boundary();

    // R8: clear serviced source 0
    cfg_write(2'd2, 4'b0001);
    check(vad == 8'h01, "R8 clear source 0", int'(vad), 1);

    // R1: clear and arrival on same bit in same cycle
    irq_in = 4'b0010;
    cfg_write(2'd2, 4'b0010);
    irq_in = '0;
    check(vad == 8'h01, "R1 arrival beats clear", int'(vad), 1);
    cfg_write(2'd2, 4'b0010);
    check(vad == 8'h02, "R8 clear source 1", int'(vad), 2);

    // R2/R4: masking all remaining sources drops ist
    cfg_write(2'd0, 4'b0011);
    tick();
    check(ist == 1'b0, "R2 mask hides pending sources", int'(ist), 0);
    cfg_write(2'd0, 4'b1111);
    tick();
    check(ist == 1'b1, "R4 ist returns", int'(ist), 1);

    // R9: back-pressure, plus boundary ignored while busy (R6)
    cfg_write(2'd1, 4'b0001);
    stk_ready = 1'b0;
    begin
      exp_t e;
      e.addr = model_sp - 8'd1; e.data = model_pc; e.vec = 8'h02;
      exp_q.push_back(e);
    end
    boundary = 1'b1; tick(); boundary = 1'b0;
    tick();
    check(stk_valid == 1'b1, "R9 push raised", int'(stk_valid), 1);
    for (int k = 0; k < 3; k++) begin
      boundary = (k == 1);
      tick();
      check(stk_valid == 1'b1 && ack == 1'b0, "R9 push held under back-pressure", int'(stk_valid), 1);
      check(stk_addr == model_sp - 8'd1 && stk_data == model_pc, "R9 push fields stable",
            int'(stk_addr), int'(model_sp - 8'd1));
    end
    boundary = 1'b0;
    stk_ready = 1'b1;
    tick();
    check(ack == 1'b1, "R9 ack after acceptance", int'(ack), 1);
    tick();
    model_sp = model_sp - 8'd1;
    model_pc = 8'h02;
    check(pc == 8'h02, "R6 busy boundary ignored", int'(pc), 2);

    // R5: enable write in ack cycle loses to the clear
    cfg_write(2'd1, 4'b0001);
    run_intr(8'h02, 1'b1);
    tick();
    check(ien == 1'b0, "R5 clear beats write", int'(ien), 0);

    tick(2);
    check(exp_q.size() == 0, "R7 all pushes seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule